// File: doc/BRIEF.md
# Rule-List Matching Pipeline

This block is the second stage of a packet classifier. It runs on its own, separate from the decision-tree walk. For each packet, the tree walk produces a leaf result. That result is presented here as a row address and a span. The span is the number of further stages that still hold rules of the same list. Alongside it come the packet's five header fields: source and destination address, source and destination port, and protocol.

The packet moves through a chain of stages, one stage per clock. Each stage owns a small rule memory and reads it once per packet. Each stage can be built in one of three ways:
- one rule per read;
- a pair of rules, taken from two adjacent rows through two read ports in the same cycle;
- a wide word holding several rules side by side.

So one stage can test several rules in a single cycle. A countdown travels with the packet and stops comparison once the list's last stage has passed. Rules are laid out in priority order. The first hit along the scan is kept, and any later hit is ignored. The result always appears a fixed number of cycles after the lookup, equal to the stage count.

Rules are loaded through a write port that addresses a stage, a row and a slot.

Top module: `rlm_match_pipe`

## Requirements
- R1: While rst_n is low, and afterwards until the first lookup result emerges, res_valid and res_hit are 0.
- R2: A lookup taken with lk_valid=1 at a clock edge produces exactly one res_valid pulse NUM_STAGES edges later. Lookups may arrive every cycle, and idle cycles are preserved.
- R3: A rule matches when all of the following hold:
  - its enable bit is 1;
  - lo <= port <= hi, inclusive, for both the source port and the destination port;
  - ((field ^ value) & mask) == 0 for the source address, the destination address and the protocol.
- R4: A rule stored with wr_rule_en=0 never matches.
- R5: The scan runs from stage 0 to the last stage. Within a pair stage, row lk_addr comes before row lk_addr+1. Within a wide stage, slot 0 comes first and higher slots follow. The ID of the first matching rule is reported, and later matches do not replace it.
- R6: When no rule matches, res_hit is 0 and res_id equals DEFAULT_ID.
- R7: Stage s compares the packet only when s <= lk_span. Stages beyond that point never produce a hit.
- R8: Stage s takes its fetch kind from STAGE_MODES bits [2s+1:2s]. Code 00 reads one rule, at row lk_addr.
- R9: Code 01 reads two rules in one cycle, from rows lk_addr and (lk_addr+1) mod DEPTH.
- R10: Code 10 reads all WIDE_K rules of row lk_addr, with slot index wr_slot chosen at write time. In one-rule and pair stages, a write with a nonzero wr_slot is ignored.
- R11: A write with wr_en=1 stores the rule fields and wr_id into stage wr_stage at row wr_addr, and slot wr_slot where the stage has slots. wr_rule_en becomes the rule's enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Rule write strobe |
| wr_stage | input | STG_W | Target stage of the write |
| wr_addr | input | AW | Target row |
| wr_slot | input | SLOT_W | Target slot within a wide row |
| wr_rule_en | input | 1 | Enable bit of the written rule |
| wr_id | input | ID_W | Rule identifier |
| wr_sip_val | input | 32 | Source address value |
| wr_sip_msk | input | 32 | Source address mask |
| wr_dip_val | input | 32 | Destination address value |
| wr_dip_msk | input | 32 | Destination address mask |
| wr_sp_lo | input | 16 | Source port lower bound |
| wr_sp_hi | input | 16 | Source port upper bound |
| wr_dp_lo | input | 16 | Destination port lower bound |
| wr_dp_hi | input | 16 | Destination port upper bound |
| wr_pr_val | input | 8 | Protocol value |
| wr_pr_msk | input | 8 | Protocol mask |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Row address of the rule list |
| lk_span | input | DIST_W | Stages after stage 0 that hold the list |
| lk_sip | input | 32 | Packet source address |
| lk_dip | input | 32 | Packet destination address |
| lk_sport | input | 16 | Packet source port |
| lk_dport | input | 16 | Packet destination port |
| lk_proto | input | 8 | Packet protocol |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A rule matched |
| res_id | output | ID_W | Matching rule ID, or DEFAULT_ID |

## Verification
The bench builds the block with four stages in the order one-rule, pair, wide (WIDE_K=4), pair, and with DEPTH=8. This mix puts every fetch kind, including a pair read that wraps from the last row to row 0, into a single scan. It sweeps every row address and every span against header sets derived from each address. Those sets hit, miss and overlap rules in each stage, so priority, masking, range edges, disabled rules and the end-of-list cut-off are all reached. A reference scan computed in the bench gives the expected results. Directed writes then confirm that a nonzero slot is ignored by a one-rule stage and honoured by a wide stage.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

   localparam int PORT_W  = 16;
   localparam int IP_W    = 32;
   localparam int PROTO_W = 8;

   // Fetch kind of one stage; two bits per stage in STAGE_MODES.
   localparam logic [1:0] FETCH_ONE  = 2'd0;
   localparam logic [1:0] FETCH_PAIR = 2'd1;
   localparam logic [1:0] FETCH_WIDE = 2'd2;

   typedef struct packed {
      logic [IP_W-1:0]    sip;
      logic [IP_W-1:0]    dip;
      logic [PORT_W-1:0]  sport;
      logic [PORT_W-1:0]  dport;
      logic [PROTO_W-1:0] proto;
   } hdr_t;

   typedef struct packed {
      logic               en;
      logic [IP_W-1:0]    sip_val;
      logic [IP_W-1:0]    sip_msk;
      logic [IP_W-1:0]    dip_val;
      logic [IP_W-1:0]    dip_msk;
      logic [PORT_W-1:0]  sp_lo;
      logic [PORT_W-1:0]  sp_hi;
      logic [PORT_W-1:0]  dp_lo;
      logic [PORT_W-1:0]  dp_hi;
      logic [PROTO_W-1:0] pr_val;
      logic [PROTO_W-1:0] pr_msk;
   } rule_t;

   function automatic int slots_of(input logic [1:0] mode, input int wide_k);
      case (mode)
         FETCH_ONE:  return 1;
         FETCH_PAIR: return 2;
         default:    return wide_k;
      endcase
   endfunction

endpackage

// File: rtl/rlm_rule_cmp.sv
module rlm_rule_cmp
   import rlm_pkg::*;
(
   input  rule_t rule,
   input  hdr_t  hdr,
   output logic  hit
);

   logic sp_ok, dp_ok, sip_ok, dip_ok, pr_ok;

   always_comb begin
      sp_ok  = (hdr.sport >= rule.sp_lo) && (hdr.sport <= rule.sp_hi);
      dp_ok  = (hdr.dport >= rule.dp_lo) && (hdr.dport <= rule.dp_hi);
      sip_ok = ((hdr.sip ^ rule.sip_val) & rule.sip_msk) == '0;
      dip_ok = ((hdr.dip ^ rule.dip_val) & rule.dip_msk) == '0;
      pr_ok  = ((hdr.proto ^ rule.pr_val) & rule.pr_msk) == '0;
      hit    = rule.en && sp_ok && dp_ok && sip_ok && dip_ok && pr_ok;
   end

endmodule

// File: rtl/rlm_stage.sv
module rlm_stage
   import rlm_pkg::*;
#(
   parameter logic [1:0] MODE   = FETCH_ONE,
   parameter int         WIDE_K = 4,
   parameter int         DEPTH  = 16,
   parameter int         ID_W   = 8,
   parameter int         DIST_W = 2,
   parameter int         SLOT_W = 2,
   parameter int         AW     = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [SLOT_W-1:0] wr_slot,
   input  rule_t             wr_rule,
   input  logic [ID_W-1:0]   wr_id,
   input  logic              in_vld,
   input  logic              in_live,
   input  logic [DIST_W-1:0] in_dist,
   input  logic [AW-1:0]     in_addr,
   input  hdr_t              in_hdr,
   input  logic              in_hit,
   input  logic [ID_W-1:0]   in_id,
   output logic              out_vld,
   output logic              out_live,
   output logic [DIST_W-1:0] out_dist,
   output logic [AW-1:0]     out_addr,
   output hdr_t              out_hdr,
   output logic              out_hit,
   output logic [ID_W-1:0]   out_id
);

   localparam int SLOTS = slots_of(MODE, WIDE_K);

   rule_t           q_rule [SLOTS];
   logic [ID_W-1:0] q_rid  [SLOTS];
   logic [SLOTS-1:0] slot_hit;

   logic              t_vld, t_live, t_hit;
   logic [DIST_W-1:0] t_dist;
   logic [AW-1:0]     t_addr;
   hdr_t              t_hdr;
   logic [ID_W-1:0]   t_id;

   // Stage memory and its synchronous read, one variant per fetch kind.
   generate
      if (MODE == FETCH_WIDE) begin : g_wide
         rule_t           mem [DEPTH][WIDE_K];
         logic [ID_W-1:0] ids [DEPTH][WIDE_K];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int r = 0; r < DEPTH; r++) begin
                  for (int k = 0; k < WIDE_K; k++) begin
                     mem[r][k] <= '0;
                     ids[r][k] <= '0;
                  end
               end
               for (int j = 0; j < SLOTS; j++) begin
                  q_rule[j] <= '0;
                  q_rid[j]  <= '0;
               end
            end else begin
               if (wr_en && (int'(wr_slot) < WIDE_K)) begin
                  mem[wr_addr][wr_slot] <= wr_rule;
                  ids[wr_addr][wr_slot] <= wr_id;
               end
               for (int j = 0; j < SLOTS; j++) begin
                  q_rule[j] <= mem[in_addr][j];
                  q_rid[j]  <= ids[in_addr][j];
               end
            end
         end
      end else begin : g_rows
         rule_t           mem [DEPTH];
         logic [ID_W-1:0] ids [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int r = 0; r < DEPTH; r++) begin
                  mem[r] <= '0;
                  ids[r] <= '0;
               end
               for (int j = 0; j < SLOTS; j++) begin
                  q_rule[j] <= '0;
                  q_rid[j]  <= '0;
               end
            end else begin
               if (wr_en && (wr_slot == '0)) begin
                  mem[wr_addr] <= wr_rule;
                  ids[wr_addr] <= wr_id;
               end
               // Pair kind: second port reads the next row, wrapping.
               for (int j = 0; j < SLOTS; j++) begin
                  q_rule[j] <= mem[in_addr + AW'(j)];
                  q_rid[j]  <= ids[in_addr + AW'(j)];
               end
            end
         end
      end
   endgenerate

   // Packet token carried alongside the read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_vld  <= 1'b0;
         t_live <= 1'b0;
         t_hit  <= 1'b0;
         t_dist <= '0;
         t_addr <= '0;
         t_hdr  <= '0;
         t_id   <= '0;
      end else begin
         t_vld  <= in_vld;
         t_live <= in_live && in_vld;
         t_hit  <= in_hit;
         t_dist <= in_dist;
         t_addr <= in_addr;
         t_hdr  <= in_hdr;
         t_id   <= in_id;
      end
   end

   generate
      for (genvar j = 0; j < SLOTS; j++) begin : g_cmp
         rlm_rule_cmp u_cmp (
            .rule (q_rule[j]),
            .hdr  (t_hdr),
            .hit  (slot_hit[j])
         );
      end
   endgenerate

   logic            found;
   logic [ID_W-1:0] pick;

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int j = 0; j < SLOTS; j++) begin
         if (slot_hit[j] && !found) begin
            found = 1'b1;
            pick  = q_rid[j];
         end
      end
   end

   always_comb begin
      out_vld  = t_vld;
      out_addr = t_addr;
      out_hdr  = t_hdr;
      out_live = t_live && (t_dist != '0);
      out_dist = (t_dist == '0) ? '0 : t_dist - 1'b1;
      if (!t_hit && t_live && found) begin
         out_hit = 1'b1;
         out_id  = pick;
      end else begin
         out_hit = t_hit;
         out_id  = t_id;
      end
   end

endmodule

// File: rtl/rlm_match_pipe.sv
module rlm_match_pipe
   import rlm_pkg::*;
#(
   parameter int                        NUM_STAGES  = 4,
   parameter int                        DEPTH       = 16,
   parameter int                        WIDE_K      = 4,
   parameter int                        ID_W        = 8,
   parameter logic [ID_W-1:0]           DEFAULT_ID  = '1,
   parameter logic [2*NUM_STAGES-1:0]   STAGE_MODES = 8'b01_10_01_00,
   localparam int AW     = $clog2(DEPTH),
   localparam int DIST_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
   localparam int STG_W  = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
   localparam int SLOT_W = (WIDE_K > 1) ? $clog2(WIDE_K) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STG_W-1:0]  wr_stage,
   input  logic [AW-1:0]     wr_addr,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_rule_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [31:0]       wr_sip_val,
   input  logic [31:0]       wr_sip_msk,
   input  logic [31:0]       wr_dip_val,
   input  logic [31:0]       wr_dip_msk,
   input  logic [15:0]       wr_sp_lo,
   input  logic [15:0]       wr_sp_hi,
   input  logic [15:0]       wr_dp_lo,
   input  logic [15:0]       wr_dp_hi,
   input  logic [7:0]        wr_pr_val,
   input  logic [7:0]        wr_pr_msk,
   input  logic              lk_valid,
   input  logic [AW-1:0]     lk_addr,
   input  logic [DIST_W-1:0] lk_span,
   input  logic [31:0]       lk_sip,
   input  logic [31:0]       lk_dip,
   input  logic [15:0]       lk_sport,
   input  logic [15:0]       lk_dport,
   input  logic [7:0]        lk_proto,
   output logic              res_valid,
   output logic              res_hit,
   output logic [ID_W-1:0]   res_id
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_STAGES < 1) begin : g_bad_stages
         $error("rlm_match_pipe: NUM_STAGES must be at least 1");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rlm_match_pipe: DEPTH must be a power of two of at least 2");
      end
      if (WIDE_K < 2) begin : g_bad_k
         $error("rlm_match_pipe: WIDE_K must be at least 2");
      end
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_mode_chk
         if (STAGE_MODES[2*s +: 2] == 2'd3) begin : g_bad_mode
            $error("rlm_match_pipe: stage fetch code 3 is undefined");
         end
      end
   endgenerate

   rule_t wr_r;
   hdr_t  lk_h;

   always_comb begin
      wr_r = '{en: wr_rule_en,
               sip_val: wr_sip_val, sip_msk: wr_sip_msk,
               dip_val: wr_dip_val, dip_msk: wr_dip_msk,
               sp_lo: wr_sp_lo, sp_hi: wr_sp_hi,
               dp_lo: wr_dp_lo, dp_hi: wr_dp_hi,
               pr_val: wr_pr_val, pr_msk: wr_pr_msk};
      lk_h = '{sip: lk_sip, dip: lk_dip, sport: lk_sport,
               dport: lk_dport, proto: lk_proto};
   end

   logic              c_vld  [NUM_STAGES+1];
   logic              c_live [NUM_STAGES+1];
   logic [DIST_W-1:0] c_dist [NUM_STAGES+1];
   logic [AW-1:0]     c_addr [NUM_STAGES+1];
   hdr_t              c_hdr  [NUM_STAGES+1];
   logic              c_hit  [NUM_STAGES+1];
   logic [ID_W-1:0]   c_id   [NUM_STAGES+1];

   assign c_vld[0]  = lk_valid;
   assign c_live[0] = lk_valid;
   assign c_dist[0] = lk_span;
   assign c_addr[0] = lk_addr;
   assign c_hdr[0]  = lk_h;
   assign c_hit[0]  = 1'b0;
   assign c_id[0]   = DEFAULT_ID;

   generate
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
         logic st_wr;
         assign st_wr = wr_en && (wr_stage == STG_W'(s));
         rlm_stage #(
            .MODE   (STAGE_MODES[2*s +: 2]),
            .WIDE_K (WIDE_K),
            .DEPTH  (DEPTH),
            .ID_W   (ID_W),
            .DIST_W (DIST_W),
            .SLOT_W (SLOT_W),
            .AW     (AW)
         ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (st_wr),
            .wr_addr  (wr_addr),
            .wr_slot  (wr_slot),
            .wr_rule  (wr_r),
            .wr_id    (wr_id),
            .in_vld   (c_vld[s]),
            .in_live  (c_live[s]),
            .in_dist  (c_dist[s]),
            .in_addr  (c_addr[s]),
            .in_hdr   (c_hdr[s]),
            .in_hit   (c_hit[s]),
            .in_id    (c_id[s]),
            .out_vld  (c_vld[s+1]),
            .out_live (c_live[s+1]),
            .out_dist (c_dist[s+1]),
            .out_addr (c_addr[s+1]),
            .out_hdr  (c_hdr[s+1]),
            .out_hit  (c_hit[s+1]),
            .out_id   (c_id[s+1])
         );
      end
   endgenerate

   assign res_valid = c_vld[NUM_STAGES];
   assign res_hit   = c_hit[NUM_STAGES];
   assign res_id    = c_id[NUM_STAGES];

endmodule

// File: rtl/rlm_chk.sv
module rlm_chk #(
   parameter int              NUM_STAGES = 4,
   parameter int              ID_W       = 8,
   parameter logic [ID_W-1:0] DEFAULT_ID = '1
)(
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic            wr_en,
   input logic            wr_rule_en,
   input logic            res_valid,
   input logic            res_hit,
   input logic [ID_W-1:0] res_id
);

   logic [NUM_STAGES-1:0] vsh;
   logic                  any_rule;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsh      <= '0;
         any_rule <= 1'b0;
      end else begin
         vsh      <= (vsh << 1) | NUM_STAGES'(lk_valid);
         any_rule <= any_rule || (wr_en && wr_rule_en);
      end
   end

   // R1: the result port stays quiet while reset is held
   p_idle_in_reset_r1: assert property (@(posedge clk) !rst_n |=> !res_valid && !res_hit);

   // R2: one result per lookup, exactly NUM_STAGES cycles later
   p_fixed_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == vsh[NUM_STAGES-1]);

   // R6: a hit is only ever reported together with a result strobe
   p_hit_in_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);

   // R6: a miss carries the default identifier
   p_miss_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> res_id == DEFAULT_ID);

   // R4: with no enabled rule ever written nothing can match
   p_no_rules_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !any_rule |-> !res_hit);

endmodule

bind rlm_match_pipe rlm_chk #(
   .NUM_STAGES (NUM_STAGES),
   .ID_W       (ID_W),
   .DEFAULT_ID (DEFAULT_ID)
) u_rlm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .wr_en      (wr_en),
   .wr_rule_en (wr_rule_en),
   .res_valid  (res_valid),
   .res_hit    (res_hit),
   .res_id     (res_id)
);

// File: tb/test_rlm_match_pipe.sv
module test_rlm_match_pipe;

   localparam int NS = 4;
   localparam int DEPTH = 8;
   localparam int K = 4;
   localparam int ID_W = 8;
   localparam logic [7:0] DEF_ID = 8'hFF;
   localparam int MAXV = 8192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2ns clk = ~clk;   // 250 MHz

   logic        wr_en = 0, wr_rule_en = 0;
   logic [1:0]  wr_stage = 0, wr_slot = 0;
   logic [2:0]  wr_addr = 0;
   logic [7:0]  wr_id = 0, wr_pr_val = 0, wr_pr_msk = 0;
   logic [31:0] wr_sip_val = 0, wr_sip_msk = 0, wr_dip_val = 0, wr_dip_msk = 0;
   logic [15:0] wr_sp_lo = 0, wr_sp_hi = 0, wr_dp_lo = 0, wr_dp_hi = 0;
   logic        lk_valid = 0;
   logic [2:0]  lk_addr = 0;
   logic [1:0]  lk_span = 0;
   logic [31:0] lk_sip = 0, lk_dip = 0;
   logic [15:0] lk_sport = 0, lk_dport = 0;
   logic [7:0]  lk_proto = 0;
   logic        res_valid, res_hit;
   logic [7:0]  res_id;

   rlm_match_pipe #(
      .NUM_STAGES (NS), .DEPTH (DEPTH), .WIDE_K (K), .ID_W (ID_W),
      .DEFAULT_ID (DEF_ID), .STAGE_MODES (8'b01_10_01_00)
   ) i_rlm_match_pipe (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_stage (wr_stage), .wr_addr (wr_addr), .wr_slot (wr_slot),
      .wr_rule_en (wr_rule_en), .wr_id (wr_id),
      .wr_sip_val (wr_sip_val), .wr_sip_msk (wr_sip_msk),
      .wr_dip_val (wr_dip_val), .wr_dip_msk (wr_dip_msk),
      .wr_sp_lo (wr_sp_lo), .wr_sp_hi (wr_sp_hi),
      .wr_dp_lo (wr_dp_lo), .wr_dp_hi (wr_dp_hi),
      .wr_pr_val (wr_pr_val), .wr_pr_msk (wr_pr_msk),
      .lk_valid (lk_valid), .lk_addr (lk_addr), .lk_span (lk_span),
      .lk_sip (lk_sip), .lk_dip (lk_dip), .lk_sport (lk_sport),
      .lk_dport (lk_dport), .lk_proto (lk_proto),
      .res_valid (res_valid), .res_hit (res_hit), .res_id (res_id)
   );

   int checks = 0, fails = 0;
   int cyc = 0;
   int wi = 0, ri = 0;
   bit done = 0;
   int    exp_id [MAXV];
   int    exp_t  [MAXV];
   string exp_tag[MAXV];

   // Stage fetch kinds as built: 0 one rule, 1 pair, 2 wide.
   int kind [NS] = '{0, 1, 2, 1};

   always @(posedge clk) cyc <= cyc + 1;

   // Rule content as a function of its global number n = (stage*8+row)*4+slot.
   function automatic bit r_en(int n);            return (n % 11) != 3;                    endfunction
   function automatic int r_splo(int n);          return (n % 5 == 0) ? 100 : 0;           endfunction
   function automatic int r_sphi(int n);          return (n % 5 == 0) ? 200 : 65535;       endfunction
   function automatic logic [31:0] r_sipv(int n); return {8'd10, 24'(n)};                 endfunction
   function automatic logic [31:0] r_sipm(int n); return (n % 3 == 0) ? 32'hFF00_0000 : 32'h0; endfunction
   function automatic logic [31:0] r_dipm(int n); return (n % 7 == 1) ? 32'hFFFF_0000 : 32'h0; endfunction
   function automatic logic [7:0]  r_prm(int n);  return (n % 4 == 2) ? 8'hFF : 8'h00;     endfunction

   function automatic bit r_hit(int n, logic [31:0] sip, logic [31:0] dip,
                                int sp, int dp, logic [7:0] pr);
      if (!r_en(n)) return 0;
      if (sp < r_splo(n) || sp > r_sphi(n)) return 0;
      if (dp < n * 2 || dp > n * 2 + 5) return 0;
      if (((sip ^ r_sipv(n)) & r_sipm(n)) != 0) return 0;
      if (((dip ^ 32'hC0A8_0000) & r_dipm(n)) != 0) return 0;
      if (((pr ^ 8'd6) & r_prm(n)) != 0) return 0;
      return 1;
   endfunction

   // Reference scan: stages 0..span, rows then slots in priority order.
   function automatic int model(int a, int span, logic [31:0] sip, logic [31:0] dip,
                                int sp, int dp, logic [7:0] pr);
      for (int s = 0; s < NS; s++) begin
         int cnt;
         if (s > span) break;
         cnt = (kind[s] == 0) ? 1 : (kind[s] == 1) ? 2 : K;
         for (int e = 0; e < cnt; e++) begin
            int row, slot, n;
            row  = (kind[s] == 2) ? a : (a + e) % DEPTH;
            slot = (kind[s] == 2) ? e : 0;
            n    = (s * 8 + row) * 4 + slot;
            if (r_hit(n, sip, dip, sp, dp, pr)) return n;
         end
      end
      return -1;
   endfunction

   task automatic put(int s, int r, int k, bit en, int id, logic [31:0] sv, logic [31:0] sm,
                      logic [31:0] dm, int splo, int sphi, int dplo, int dphi, logic [7:0] pm);
      wr_en = 1; wr_stage = 2'(s); wr_addr = 3'(r); wr_slot = 2'(k);
      wr_rule_en = en; wr_id = 8'(id);
      wr_sip_val = sv; wr_sip_msk = sm; wr_dip_val = 32'hC0A8_0000; wr_dip_msk = dm;
      wr_sp_lo = 16'(splo); wr_sp_hi = 16'(sphi); wr_dp_lo = 16'(dplo); wr_dp_hi = 16'(dphi);
      wr_pr_val = 8'd6; wr_pr_msk = pm;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic issue(int a, int span, logic [31:0] sip, logic [31:0] dip,
                        int sp, int dp, logic [7:0] pr, int forced, string tag);
      lk_valid = 1; lk_addr = 3'(a); lk_span = 2'(span);
      lk_sip = sip; lk_dip = dip; lk_sport = 16'(sp); lk_dport = 16'(dp); lk_proto = pr;
      exp_id[wi]  = (forced == -2) ? model(a, span, sip, dip, sp, dp, pr) : forced;
      exp_t[wi]   = cyc + NS;
      exp_tag[wi] = tag;
      wi++;
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // Output monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (rst_n && res_valid && !done) begin
         checks++;
         if (ri >= wi) begin
            fails++;
            $display("FAIL R2: unexpected result at cycle %0d, got 1 expected 0", cyc);
         end else begin
            int  e_id;
            bit  e_hit;
            e_hit = exp_id[ri] >= 0;
            e_id  = e_hit ? exp_id[ri] : int'(DEF_ID);
            if (cyc != exp_t[ri]) begin
               fails++;
               $display("FAIL R2: result %0d at cycle %0d expected cycle %0d", ri, cyc, exp_t[ri]);
            end else if (res_hit !== e_hit || int'(res_id) != e_id) begin
               fails++;
               $display("FAIL %s: vector %0d got hit=%0d id=%0h expected hit=%0d id=%0h",
                        exp_tag[ri], ri, res_hit, res_id, e_hit, e_id);
            end
            ri++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL R2: watchdog expired with %0d of %0d results seen", ri, wi);
         summary();
         $finish;
      end
   end

   localparam logic [31:0] SIPS [2] = '{32'h0A00_0005, 32'h0B00_0005};
   localparam logic [31:0] DIPS [2] = '{32'hC0A8_0101, 32'h0102_0304};
   localparam int          SPS  [2] = '{50, 150};
   localparam logic [7:0]  PRS  [2] = '{8'd6, 8'd17};
   localparam int          OFFS [3] = '{0, 3, 7};

   initial begin
      int nv;
      // R1: quiet during reset
      repeat (3) @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
         fails++;
         $display("FAIL R1: in reset got valid=%0b hit=%0b expected 0 0", res_valid, res_hit);
      end
      rst_n = 1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
         fails++;
         $display("FAIL R1: after reset got valid=%0b hit=%0b expected 0 0", res_valid, res_hit);
      end

      // R11: load every stage; wide stage fills all four slots of each row
      for (int s = 0; s < NS; s++)
         for (int r = 0; r < DEPTH; r++)
            for (int k = 0; k < ((kind[s] == 2) ? K : 1); k++) begin
               int n;
               n = (s * 8 + r) * 4 + k;
               put(s, r, k, r_en(n), n, r_sipv(n), r_sipm(n), r_dipm(n),
                   r_splo(n), r_sphi(n), n * 2, n * 2 + 5, r_prm(n));
            end

      // Sweep: R3 R4 R5 R6 R7 R8 R9 R10 against the reference scan, with bubbles for R2
      nv = 0;
      for (int a = 0; a < DEPTH; a++)
         for (int span = 0; span < NS; span++)
            for (int s2 = 0; s2 < NS; s2++)
               for (int o = 0; o < 3; o++)
                  for (int h = 0; h < 16; h++) begin
                     int dp;
                     dp = (s2 * 8 + a) * 8 + OFFS[o];
                     issue(a, span, SIPS[h[0]], DIPS[h[1]], SPS[h[2]], dp, PRS[h[3]], -2,
                           "R3 R4 R5 R6 R7 R8 R9");
                     nv++;
                     if (nv % 7 == 6) @(negedge clk);
                  end

      // R10: nonzero slot written to a one-rule stage is ignored
      put(0, 2, 1, 1, 8'h77, 32'h0, 32'h0, 32'h0, 0, 65535, 0, 65535, 8'h00);
      issue(2, 0, 32'h0A00_0005, 32'h0102_0304, 50, 60000, 8'd17, -1, "R10");
      // R10: slot 3 of a wide stage is scanned after slots 0..2
      put(2, 5, 3, 1, 8'h66, 32'h0, 32'h0, 32'h0, 0, 65535, 0, 65535, 8'h00);
      issue(5, 2, 32'h0A00_0005, 32'h0102_0304, 50, 60000, 8'd17, 8'h66, "R10");
      // R7: same lookup with span 1 stops before the wide stage
      issue(5, 1, 32'h0A00_0005, 32'h0102_0304, 50, 60000, 8'd17, -1, "R7");
      // R9: pair stage 3 wraps from row 7 to row 0
      issue(7, 3, 32'h0A00_0005, 32'h0102_0304, 50, (3 * 8 + 0) * 8 + 1, 8'd17,
            model(7, 3, 32'h0A00_0005, 32'h0102_0304, 50, (3 * 8 + 0) * 8 + 1, 8'd17), "R9");

      repeat (NS + 4) @(negedge clk);
      checks++;
      if (ri != wi) begin
         fails++;
         $display("FAIL R2: results seen %0d expected %0d", ri, wi);
      end
      done = 1;
      summary();
      $finish;
   end

endmodule